// File: doc/BRIEF.md
# Multi-Channel Audio Sample Fetcher with Input Register Bank

This block gathers 16-bit audio samples from external memory on behalf of a sample-processing core. Thirteen independent fetch channels each walk a region of external memory. Each channel has its own start address, sample count and enable. A channel fetches one sample per memory transaction and parks the samples in its own eight-entry FIFO. The core reads samples out of a 128-word register bank. Words 0 to 12 each belong to one channel. Every core read of a channel's word hands back the current contents and pulls the next FIFO entry into that word. The remaining 115 words are scratch storage. The host can write them, and the core can read them.

The memory side is a request/grant/return-valid port that carries one transaction at a time. A fetch state machine has three states: IDLE (no transaction), ISSUE (request held until granted) and WAIT (awaiting the returned sample). Its transitions are: IDLE to ISSUE when any channel requests (the arbiter picks the channel); ISSUE to WAIT on `mem_gnt`; WAIT to IDLE on `mem_rvalid`. A round-robin arbiter chooses among the channels that want a refill.

Access to the bank is asymmetric. The host has a write path and no read path. A host read attempt is refused with an error pulse. The core has a read path only.

Top module: `audio_fetch_bank`

## Requirements
- R1: After reset, `mem_req`, `host_err`, `core_rdata`, `chan_done` and `chan_underflow` are 0, and every bank word reads as 0.
- R2: Channel c owns bank word c (c = 0..12). A core read of word c returns that word's present contents on `core_rdata` one cycle later. In the same edge, the read loads the word with the oldest sample in the channel's FIFO. Samples arrive in the order of their memory addresses.
- R3: A core read of channel word c while that channel's FIFO is empty leaves the word unchanged and sets `chan_underflow[c]`. The flag stays set until a control write to that channel.
- R4: Each FIFO holds 8 samples. A channel asks for a refill only while it is enabled, its remaining count is nonzero, and its FIFO holds 4 or fewer samples. With no core reads, a channel therefore fetches exactly 5 samples and its FIFO never overflows.
- R5: Requesting channels are granted round-robin. The search starts at the channel after the last one granted and wraps from 12 to 0. Only one grant is made per memory transaction, and at most one transaction is outstanding.
- R6: `mem_req` stays high with a stable `mem_addr` until `mem_gnt` is seen. The block then accepts exactly one `mem_rvalid` with the sample on `mem_rdata`.
- R7: A channel fetches from its start address, start+1, start+2 and so on, for as many samples as its count. After the last sample has returned, `chan_done[c]` is set and the channel stops.
- R8: A host write to bank words 13..127 is visible to a core read issued in the following cycle. A host write to a channel word (0..12) is dropped.
- R9: A host read request is refused. `host_err` is high in the cycle after `host_re` and low otherwise, and the bank is left unchanged.
- R10: Configuration writes use `cfg_field` to select the target. Field 0 sets the start address, field 1 sets the sample count, and field 2 is control, where bit 0 is the enable. A control write also clears that channel's done and underflow flags.
- R11: A core read of a non-channel word (13..127) pops no FIFO and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 4 | Channel selected by a configuration write |
| cfg_field | input | 2 | 0 start address, 1 sample count, 2 control (bit 0 enable) |
| cfg_wdata | input | 24 | Configuration write data |
| host_we | input | 1 | Host bank write strobe |
| host_re | input | 1 | Host bank read attempt (always refused) |
| host_addr | input | 7 | Host bank word address |
| host_wdata | input | 16 | Host bank write data |
| host_err | output | 1 | Pulses one cycle after a refused host read |
| core_re | input | 1 | Core bank read strobe |
| core_addr | input | 7 | Core bank word address |
| core_rdata | output | 16 | Core read data, valid the cycle after `core_re` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 24 | Memory sample address |
| mem_gnt | input | 1 | Memory accepted the request |
| mem_rvalid | input | 1 | Returned sample valid |
| mem_rdata | input | 16 | Returned sample |
| chan_done | output | 13 | Per-channel completion flags |
| chan_underflow | output | 13 | Per-channel sticky underflow flags |

## Verification
The bench drains a channel past its last sample. A design that popped garbage or failed to set the flag would return a value other than the held last sample, or leave the underflow flag clear. It holds the memory grant off while three channels become ready. The resulting fetch address order exposes an arbiter that restarts at channel 0, or one that grants twice before a transaction ends. It also counts fetches with no core reads. An off-by-one refill threshold shows up as a fetch count other than 5. Host writes to channel words and host read attempts are issued against known contents. A design that let either disturb the bank would return the wrong word to the core.

// File: rtl/afb_pkg.sv
package afb_pkg;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_ISSUE = 2'd1,
        FS_WAIT  = 2'd2
    } fetch_state_t;

    typedef enum logic [1:0] {
        CFG_START  = 2'd0,
        CFG_LENGTH = 2'd1,
        CFG_CTRL   = 2'd2
    } cfg_field_t;

endpackage

// File: rtl/afb_fifo.sv
module afb_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  slot_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slot_q[rd_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            count <= '0;
        end else begin
            if (do_push)
                wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (do_pop)
                rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push)
            slot_q[wr_q] <= din;
    end
endmodule

// File: rtl/afb_rr_arb.sv
module afb_rr_arb #(
    parameter int N   = 13,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          advance,
    output logic [IW-1:0] pick,
    output logic          any
);
    logic [IW-1:0] ptr_q;
    logic [IW:0]   cand;

    // Search downward in offset so the lowest offset from the pointer wins.
    always_comb begin
        pick = '0;
        any  = 1'b0;
        cand = '0;
        for (int off = N - 1; off >= 0; off--) begin
            cand = {1'b0, ptr_q} + (IW + 1)'(off);
            if (cand >= (IW + 1)'(N))
                cand = cand - (IW + 1)'(N);
            if (req[cand[IW-1:0]]) begin
                pick = cand[IW-1:0];
                any  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (advance && any)
            ptr_q <= (pick == IW'(N - 1)) ? '0 : pick + 1'b1;
    end
endmodule

// File: rtl/afb_chan.sv
module afb_chan #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16,
    parameter int CNT_W  = 4,
    parameter int REFILL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_start_we,
    input  logic              cfg_len_we,
    input  logic              cfg_ctrl_we,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic              issue,
    input  logic              resp,
    input  logic              underflow_evt,
    output logic              req,
    output logic [ADDR_W-1:0] next_addr,
    output logic              done,
    output logic              underflow
);
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  left_q;
    logic              en_q, done_q, uf_q;

    assign req       = en_q && (left_q != '0) && (fifo_count <= CNT_W'(REFILL));
    assign next_addr = addr_q;
    assign done      = done_q;
    assign underflow = uf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
            en_q   <= 1'b0;
            done_q <= 1'b0;
            uf_q   <= 1'b0;
        end else begin
            if (cfg_start_we)
                addr_q <= cfg_wdata;
            else if (issue)
                addr_q <= addr_q + 1'b1;

            if (cfg_len_we)
                left_q <= cfg_wdata[LEN_W-1:0];
            else if (issue)
                left_q <= left_q - 1'b1;

            if (cfg_ctrl_we) begin
                en_q   <= cfg_wdata[0];
                done_q <= 1'b0;
                uf_q   <= 1'b0;
            end else begin
                if (resp && (left_q == '0)) begin
                    done_q <= 1'b1;
                    en_q   <= 1'b0;
                end
                if (underflow_evt)
                    uf_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/audio_fetch_bank.sv
module audio_fetch_bank
    import afb_pkg::*;
#(
    parameter int NUM_CH       = 13,
    parameter int DATA_W       = 16,
    parameter int ADDR_W       = 24,
    parameter int LEN_W        = 16,
    parameter int BANK_DEPTH   = 128,
    parameter int FIFO_DEPTH   = 8,
    parameter int REFILL_LEVEL = 4,
    localparam int CH_W        = $clog2(NUM_CH),
    localparam int BANK_AW     = $clog2(BANK_DEPTH),
    localparam int CNT_W       = $clog2(FIFO_DEPTH + 1),
    localparam int FREE_N      = BANK_DEPTH - NUM_CH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CH_W-1:0]    cfg_ch,
    input  logic [1:0]         cfg_field,
    input  logic [ADDR_W-1:0]  cfg_wdata,
    input  logic               host_we,
    input  logic               host_re,
    input  logic [BANK_AW-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic               host_err,
    input  logic               core_re,
    input  logic [BANK_AW-1:0] core_addr,
    output logic [DATA_W-1:0]  core_rdata,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_gnt,
    input  logic               mem_rvalid,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [NUM_CH-1:0]  chan_done,
    output logic [NUM_CH-1:0]  chan_underflow
);
    fetch_state_t      state_q, state_d;
    cfg_field_t        cfg_kind;
    logic [CH_W-1:0]   sel_q, pick;
    logic [ADDR_W-1:0] addr_q;
    logic              any, advance, resp_fire;

    logic [NUM_CH-1:0] req_vec, issue_vec, push_vec, pop_vec, rd_hit;
    logic [NUM_CH-1:0] uf_evt, empty_vec, full_vec, cfg_hit;
    logic [DATA_W-1:0] head_arr  [NUM_CH];
    logic [CNT_W-1:0]  cnt_arr   [NUM_CH];
    logic [ADDR_W-1:0] chan_addr [NUM_CH];

    logic [DATA_W-1:0] chan_word_q [NUM_CH];
    logic [DATA_W-1:0] free_word_q [FREE_N];
    logic [DATA_W-1:0] rd_word;

    assign cfg_kind = cfg_field_t'(cfg_field);
    assign advance  = (state_q == FS_IDLE) && any;

    afb_rr_arb #(.N(NUM_CH)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_vec),
        .advance (advance),
        .pick    (pick),
        .any     (any)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign cfg_hit[c]   = cfg_we && (cfg_ch == CH_W'(c));
        assign issue_vec[c] = advance && (pick == CH_W'(c));
        assign push_vec[c]  = resp_fire && (sel_q == CH_W'(c));
        assign rd_hit[c]    = core_re && (core_addr == BANK_AW'(c));
        assign pop_vec[c]   = rd_hit[c] && !empty_vec[c];
        assign uf_evt[c]    = rd_hit[c] && empty_vec[c];

        afb_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push_vec[c]),
            .pop   (pop_vec[c]),
            .din   (mem_rdata),
            .head  (head_arr[c]),
            .count (cnt_arr[c]),
            .empty (empty_vec[c]),
            .full  (full_vec[c])
        );

        afb_chan #(
            .ADDR_W (ADDR_W),
            .LEN_W  (LEN_W),
            .CNT_W  (CNT_W),
            .REFILL (REFILL_LEVEL)
        ) u_chan (
            .clk           (clk),
            .rst_n         (rst_n),
            .cfg_start_we  (cfg_hit[c] && (cfg_kind == CFG_START)),
            .cfg_len_we    (cfg_hit[c] && (cfg_kind == CFG_LENGTH)),
            .cfg_ctrl_we   (cfg_hit[c] && (cfg_kind == CFG_CTRL)),
            .cfg_wdata     (cfg_wdata),
            .fifo_count    (cnt_arr[c]),
            .issue         (issue_vec[c]),
            .resp          (push_vec[c]),
            .underflow_evt (uf_evt[c]),
            .req           (req_vec[c]),
            .next_addr     (chan_addr[c]),
            .done          (chan_done[c]),
            .underflow     (chan_underflow[c])
        );
    end

    // Fetch state register and transaction latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            sel_q   <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (advance) begin
                sel_q  <= pick;
                addr_q <= chan_addr[pick];
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:  if (any)        state_d = FS_ISSUE;
            FS_ISSUE: if (mem_gnt)    state_d = FS_WAIT;
            FS_WAIT:  if (mem_rvalid) state_d = FS_IDLE;
            default:                  state_d = FS_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        mem_req   = 1'b0;
        resp_fire = 1'b0;
        mem_addr  = addr_q;
        unique case (state_q)
            FS_ISSUE: mem_req   = 1'b1;
            FS_WAIT:  resp_fire = mem_rvalid;
            default:  ;
        endcase
    end

    // Channel-owned words: loaded only from their FIFO
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++)
                chan_word_q[c] <= '0;
        end else begin
            for (int c = 0; c < NUM_CH; c++)
                if (pop_vec[c])
                    chan_word_q[c] <= head_arr[c];
        end
    end

    // Free words: written only by the host
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < FREE_N; w++)
                free_word_q[w] <= '0;
        end else begin
            for (int w = 0; w < FREE_N; w++)
                if (host_we && (host_addr == BANK_AW'(w + NUM_CH)))
                    free_word_q[w] <= host_wdata;
        end
    end

    always_comb begin
        if (core_addr < BANK_AW'(NUM_CH))
            rd_word = chan_word_q[core_addr[CH_W-1:0]];
        else
            rd_word = free_word_q[core_addr - BANK_AW'(NUM_CH)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_rdata <= '0;
            host_err   <= 1'b0;
        end else begin
            host_err <= host_re;
            if (core_re)
                core_rdata <= rd_word;
        end
    end
endmodule

// File: rtl/afb_checker.sv
module afb_checker #(
    parameter int NUM_CH = 13,
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              host_re,
    input logic              host_err,
    input logic              cfg_we,
    input logic [NUM_CH-1:0] chan_underflow,
    input logic [NUM_CH-1:0] issue_vec,
    input logic [NUM_CH-1:0] fifo_push,
    input logic [NUM_CH-1:0] fifo_full
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr))); // R6

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_vec)); // R5

    AST_NO_GRANT_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (issue_vec == '0)); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((fifo_push & fifo_full) == '0)); // R4

    AST_HOST_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        host_re |=> host_err); // R9

    AST_HOST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !host_re |=> !host_err); // R9

    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ((chan_underflow & $past(chan_underflow)) == $past(chan_underflow))); // R3
endmodule

bind audio_fetch_bank afb_checker #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) u_afb_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .mem_req        (mem_req),
    .mem_gnt        (mem_gnt),
    .mem_addr       (mem_addr),
    .host_re        (host_re),
    .host_err       (host_err),
    .cfg_we         (cfg_we),
    .chan_underflow (chan_underflow),
    .issue_vec      (issue_vec),
    .fifo_push      (push_vec),
    .fifo_full      (full_vec)
);

// File: tb/audio_fetch_bank_bench.sv
module audio_fetch_bank_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_ch = '0;
    logic [1:0]  cfg_field = '0;
    logic [23:0] cfg_wdata = '0;
    logic        host_we = 1'b0, host_re = 1'b0;
    logic [6:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_err;
    logic        core_re = 1'b0;
    logic [6:0]  core_addr = '0;
    logic [15:0] core_rdata;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic        mem_gnt, mem_rvalid;
    logic [15:0] mem_rdata;
    logic [12:0] chan_done, chan_underflow;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    bit mem_hold = 1'b0;
    logic [23:0] glog[$];
    logic [15:0] exp_q[$];
    string       tag_q[$];

    audio_fetch_bank u_audio_fetch_bank (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_err(host_err),
        .core_re(core_re), .core_addr(core_addr), .core_rdata(core_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .chan_done(chan_done), .chan_underflow(chan_underflow)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [15:0] mem_val(input logic [23:0] a);
        return (a[15:0] * 16'd7) + 16'd259;
    endfunction

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input int ch, input int field, input logic [23:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 4'(ch); cfg_field = 2'(field); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic host_write(input int addr, input logic [15:0] data);
        @(negedge clk);
        host_we = 1'b1; host_addr = 7'(addr); host_wdata = data;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    // Driver: issues a core read and queues the expected word for the monitor.
    task automatic core_read(input int addr, input logic [15:0] exp, input string req);
        @(negedge clk);
        core_re = 1'b1; core_addr = 7'(addr);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        core_re = 1'b0;
    endtask

    // Monitor: compares read data a quarter period after the capturing edge.
    initial begin
        logic [15:0] e;
        string t;
        forever begin
            @(posedge clk);
            if (core_re) begin
                #(CLK_PERIOD / 4);
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check_eq(t, "core_rdata", 32'(core_rdata), 32'(e));
            end
        end
    end

    // External memory responder: grant, then return the sample two cycles later.
    initial begin
        logic [23:0] a;
        mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_req && !mem_hold) begin
                a = mem_addr;
                glog.push_back(a);
                mem_gnt = 1'b1;
                @(negedge clk);
                mem_gnt = 1'b0;
                @(negedge clk);
                mem_rvalid = 1'b1; mem_rdata = mem_val(a);
                @(negedge clk);
                mem_rvalid = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [23:0] rr_exp [9];
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_eq("R1", "mem_req", 32'(mem_req), 0);
        check_eq("R1", "host_err", 32'(host_err), 0);
        check_eq("R1", "core_rdata", 32'(core_rdata), 0);
        check_eq("R1", "chan_done", 32'(chan_done), 0);
        check_eq("R1", "chan_underflow", 32'(chan_underflow), 0);
        core_read(50, 16'h0000, "R1");

        // R10/R4: configure channel 2 and let it prefetch with no reads
        cfg_write(2, 0, 24'h001000);
        cfg_write(2, 1, 24'd10);
        glog.delete();
        cfg_write(2, 2, 24'd1);
        repeat (60) @(negedge clk);
        check_eq("R4", "prefetch count", 32'(glog.size()), 5);
        check_eq("R7", "done before end", 32'(chan_done[2]), 0);
        for (int i = 0; i < 5; i++)
            check_eq("R7", "fetch address", 32'(glog[i]), 32'(24'h001000 + i));

        // R2: reads hand back the previous word and load the next sample
        for (int k = 0; k < 10; k++) begin
            core_read(2, (k == 0) ? 16'h0000 : mem_val(24'h001000 + 24'(k - 1)), "R2");
            repeat (15) @(negedge clk);
        end
        check_eq("R3", "no underflow yet", 32'(chan_underflow[2]), 0);
        check_eq("R7", "done after last", 32'(chan_done[2]), 1);
        check_eq("R7", "total fetches", 32'(glog.size()), 10);
        check_eq("R7", "last address", 32'(glog[9]), 32'(24'h001009));

        // R3: read with empty FIFO keeps the word and sets the sticky flag
        core_read(2, mem_val(24'h001009), "R3");
        @(negedge clk);
        check_eq("R3", "underflow set", 32'(chan_underflow[2]), 1);
        core_read(2, mem_val(24'h001009), "R3");
        repeat (3) @(negedge clk);
        check_eq("R3", "underflow held", 32'(chan_underflow[2]), 1);

        // R8/R11: free word written by host, read twice without popping
        host_write(20, 16'hBEEF);
        core_read(20, 16'hBEEF, "R8");
        core_read(20, 16'hBEEF, "R11");
        @(negedge clk);
        check_eq("R11", "flags untouched", 32'(chan_underflow), 32'(13'b0_0000_0000_0100));
        host_write(2, 16'h1234);
        core_read(2, mem_val(24'h001009), "R8");

        // R9: host read is refused with a one-cycle error pulse
        @(negedge clk);
        host_re = 1'b1; host_addr = 7'd20;
        @(negedge clk);
        host_re = 1'b0;
        check_eq("R9", "host_err pulse", 32'(host_err), 1);
        @(negedge clk);
        check_eq("R9", "host_err clear", 32'(host_err), 0);
        core_read(20, 16'hBEEF, "R9");

        // R10: control write clears done and underflow
        cfg_write(2, 2, 24'd0);
        check_eq("R10", "done cleared", 32'(chan_done[2]), 0);
        check_eq("R10", "underflow cleared", 32'(chan_underflow[2]), 0);

        // R5/R6: hold the grant while three channels become ready
        mem_hold = 1'b1;
        glog.delete();
        cfg_write(0, 0, 24'h002000); cfg_write(0, 1, 24'd3);
        cfg_write(5, 0, 24'h005000); cfg_write(5, 1, 24'd3);
        cfg_write(12, 0, 24'h00C000); cfg_write(12, 1, 24'd3);
        cfg_write(0, 2, 24'd1);
        cfg_write(5, 2, 24'd1);
        cfg_write(12, 2, 24'd1);
        check_eq("R6", "req while held", 32'(mem_req), 1);
        check_eq("R6", "addr while held", 32'(mem_addr), 32'(24'h002000));
        repeat (5) @(negedge clk);
        check_eq("R6", "req still held", 32'(mem_req), 1);
        check_eq("R6", "addr still held", 32'(mem_addr), 32'(24'h002000));
        mem_hold = 1'b0;
        repeat (80) @(negedge clk);
        for (int r = 0; r < 3; r++) begin
            rr_exp[3 * r + 0] = 24'h002000 + 24'(r);
            rr_exp[3 * r + 1] = 24'h005000 + 24'(r);
            rr_exp[3 * r + 2] = 24'h00C000 + 24'(r);
        end
        check_eq("R5", "grant count", 32'(glog.size()), 9);
        for (int i = 0; i < 9; i++)
            check_eq("R5", "grant order", (i < glog.size()) ? 32'(glog[i]) : 32'hFFFF_FFFF,
                     32'(rr_exp[i]));
        check_eq("R7", "three channels done", 32'(chan_done), 32'(13'b1_0000_0010_0001));

        repeat (5) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule